// File: doc/BRIEF.md
# Super I/O Configuration Unlock Port

This block is the configuration window of a multi-function I/O controller. The host reaches it through two byte-wide ports: an index port and a data port, at offsets 0 and 1 of the window's base address. After reset the window is locked. In that state the only thing that has an effect is a four-byte key written to the index port. The key's final byte depends on which of two base addresses the window is strapped to. The strap is given by `alt_base_i`: 0 selects the primary base and 1 selects the alternate base.

Once the key has been accepted, a write to the index port selects a configuration register, and data-port accesses then read or write that register. The registers are:
- a read-only 16-bit chip identifier;
- a logical-device selector;
- a global flash control byte;
- a 16-bit flash I/O base, which is only visible while the flash logical device is selected.

Writing the exit bit to the exit register locks the window again. The flash control byte and the flash base are brought out as ports, so that other logic can use them.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the window is locked (`unlocked_o`=0), `flash_ctrl_o`=0x00 and `flash_base_o`=0x0000.
- R2: With `alt_base_i`=0, writing 0x87, 0x01, 0x55, 0x55 in that order to the index port (`port_sel_i`=0) sets `unlocked_o` in the cycle after the fourth write.
- R3: With `alt_base_i`=1, the fourth key byte is 0xAA. The sequence ending in 0x55 does not unlock the window there, and a sequence ending in 0xAA does not unlock it at the primary base.
- R4: An index write that does not match the expected key byte restarts matching. If that byte is 0x87, it counts as the first key byte, so 0x87,0x01,0x87,0x01,0x55,0x55 unlocks the window.
- R5: While the window is locked, data-port writes change nothing. A read of either port (`rd_i`=1) returns 0xFF.
- R6: While the window is unlocked, an index-port write stores the register index, and an index-port read returns it.
- R7: Register 0x20 reads back the identifier's high byte (default 0x87) and register 0x21 reads back its low byte (default 0x16). Writes to either register have no effect.
- R8: Register 0x07 holds the logical-device number and can be read and written. Registers 0x64 and 0x65 reach the flash base only while the device number is 0x07. Otherwise they read 0x00 and ignore writes.
- R9: Register 0x64 holds the high byte of `flash_base_o` and register 0x65 holds its low byte. The low byte is stored with bits [2:0] cleared.
- R10: Register 0x24 is a read/write byte driven on `flash_ctrl_o`. Its fields are: bit 0 suspend, bits 1–3 segment enables, bit 4 flash write enable, bit 5 pin select.
- R11: A data write to register 0x02 with bit 1 set locks the window (`unlocked_o`=0 the next cycle). A write there with bit 1 clear leaves the window unlocked.
- R12: Any other register reads 0x00 and ignores writes. With `rd_i`=0, `rdata_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alt_base_i | input | 1 | Base strap: 0 selects the primary base, 1 selects the alternate base |
| port_sel_i | input | 1 | Port select: 0 index port, 1 data port |
| wr_i | input | 1 | Write strobe, one access per cycle |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational while `rd_i` is high |
| unlocked_o | output | 1 | Configuration window open |
| flash_ctrl_o | output | 8 | Global flash control byte |
| flash_base_o | output | 16 | Flash I/O base address |

## Verification
The hardest state to reach is a partial key match that breaks on a byte which is itself a valid restart. The stimulus reaches it with an interleaved 0x87,0x01,0x87 prefix. It also drives a full key whose last byte belongs to the other base strap, which shows that the final byte is decoded per strap. A second hard case is a data write to the flash base while a different logical device is selected. The stimulus re-selects device 7 afterwards and reads the base back through the data port, which proves the earlier write left it untouched.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam int unsigned DW = 8;
  typedef logic [DW-1:0] byte_t;

  localparam int unsigned KEY_LEN = 4;
  localparam byte_t KEY_FIRST  = 8'h87;

  localparam byte_t REG_EXIT  = 8'h02;
  localparam byte_t REG_LDN   = 8'h07;
  localparam byte_t REG_ID_HI = 8'h20;
  localparam byte_t REG_ID_LO = 8'h21;
  localparam byte_t REG_FCTL  = 8'h24;
  localparam byte_t REG_FB_HI = 8'h64;
  localparam byte_t REG_FB_LO = 8'h65;
  localparam int unsigned EXIT_BIT = 1;

  // last key byte depends on base strap
  function automatic byte_t key_byte(input int unsigned pos, input logic alt);
    case (pos)
      0:       key_byte = KEY_FIRST;
      1:       key_byte = 8'h01;
      2:       key_byte = 8'h55;
      default: key_byte = alt ? 8'hAA : 8'h55;
    endcase
  endfunction
endpackage

// File: rtl/sio_key_match.sv
module sio_key_match
  import sio_cfg_pkg::*;
#(
  parameter int unsigned LEN = KEY_LEN
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  logic  alt_i,
  input  byte_t byte_i,
  output logic  hit_o
);
  localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt_q;
  logic          match;

  assign match = (byte_i == key_byte(int'(cnt_q), alt_i));
  assign hit_o = en_i && match && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (en_i) begin
      if (match) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
      else       cnt_q <= (byte_i == KEY_FIRST) ? CW'(1) : '0;
    end
  end
endmodule

// File: rtl/sio_reg_file.sv
module sio_reg_file
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] CHIP_ID    = 16'h8716,
  parameter byte_t       FLASH_LDN  = 8'h07,
  parameter int unsigned BASE_ALIGN = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  byte_t       idx_i,
  input  byte_t       wdata_i,
  output byte_t       rdata_o,
  output logic        exit_o,
  output byte_t       flash_ctrl_o,
  output logic [15:0] flash_base_o
);
  localparam byte_t LO_MASK = ~byte_t'((1 << BASE_ALIGN) - 1);

  byte_t ldn_q, ctrl_q, fb_hi_q, fb_lo_q;
  logic  dev_hit;

  assign dev_hit = (ldn_q == FLASH_LDN);
  assign exit_o  = wr_i && (idx_i == REG_EXIT) && wdata_i[EXIT_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ldn_q   <= '0;
      ctrl_q  <= '0;
      fb_hi_q <= '0;
      fb_lo_q <= '0;
    end else if (wr_i) begin
      case (idx_i)
        REG_LDN:   ldn_q  <= wdata_i;
        REG_FCTL:  ctrl_q <= wdata_i;
        REG_FB_HI: if (dev_hit) fb_hi_q <= wdata_i;
        REG_FB_LO: if (dev_hit) fb_lo_q <= wdata_i & LO_MASK;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (idx_i)
      REG_LDN:   rdata_o = ldn_q;
      REG_ID_HI: rdata_o = CHIP_ID[15:8];
      REG_ID_LO: rdata_o = CHIP_ID[7:0];
      REG_FCTL:  rdata_o = ctrl_q;
      REG_FB_HI: rdata_o = dev_hit ? fb_hi_q : '0;
      REG_FB_LO: rdata_o = dev_hit ? fb_lo_q : '0;
      default:   rdata_o = '0;
    endcase
  end

  assign flash_ctrl_o = ctrl_q;
  assign flash_base_o = {fb_hi_q, fb_lo_q};
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] CHIP_ID    = 16'h8716,
  parameter logic [7:0]  FLASH_LDN  = 8'h07,
  parameter int unsigned BASE_ALIGN = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        alt_base_i,
  input  logic        port_sel_i,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output logic        unlocked_o,
  output logic [7:0]  flash_ctrl_o,
  output logic [15:0] flash_base_o
);
  logic  unl_q;
  byte_t idx_q;
  logic  key_en, key_hit, rf_wr, rf_exit;
  byte_t rf_rdata;

  assign key_en = !unl_q && wr_i && !port_sel_i;
  assign rf_wr  = unl_q && wr_i && port_sel_i;

  sio_key_match #(.LEN(KEY_LEN)) u_key (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (key_en),
    .alt_i  (alt_base_i),
    .byte_i (wdata_i),
    .hit_o  (key_hit)
  );

  sio_reg_file #(
    .CHIP_ID    (CHIP_ID),
    .FLASH_LDN  (FLASH_LDN),
    .BASE_ALIGN (BASE_ALIGN)
  ) u_rf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (rf_wr),
    .idx_i        (idx_q),
    .wdata_i      (wdata_i),
    .rdata_o      (rf_rdata),
    .exit_o       (rf_exit),
    .flash_ctrl_o (flash_ctrl_o),
    .flash_base_o (flash_base_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unl_q <= 1'b0;
      idx_q <= '0;
    end else begin
      if (key_hit)      unl_q <= 1'b1;
      else if (rf_exit) unl_q <= 1'b0;
      if (unl_q && wr_i && !port_sel_i) idx_q <= wdata_i;
    end
  end

  always_comb begin
    if (!rd_i)          rdata_o = '0;
    else if (!unl_q)    rdata_o = 8'hFF;
    else if (port_sel_i) rdata_o = rf_rdata;
    else                rdata_o = idx_q;
  end

  assign unlocked_o = unl_q;
endmodule

// File: rtl/sio_cfg_chk.sv
module sio_cfg_chk #(
  parameter int unsigned BASE_ALIGN = 3
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        alt_base_i,
  input logic        port_sel_i,
  input logic        wr_i,
  input logic        rd_i,
  input logic [7:0]  wdata_i,
  input logic [7:0]  rdata_o,
  input logic        unlocked_o,
  input logic [7:0]  flash_ctrl_o,
  input logic [15:0] flash_base_o,
  input logic [7:0]  idx_q
);
  a_r2_unlock_by_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlocked_o) |-> ($past(wr_i) && !$past(port_sel_i) &&
      $past(wdata_i) == ($past(alt_base_i) ? 8'hAA : 8'h55)));

  a_r5_locked_read_ff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unlocked_o && rd_i) |-> (rdata_o == 8'hFF));

  a_r5_locked_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unlocked_o && wr_i && port_sel_i) |=> ($stable(flash_ctrl_o) && $stable(flash_base_o)));

  a_r6_index_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlocked_o && wr_i && !port_sel_i) |=> (idx_q == $past(wdata_i)));

  a_r9_base_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_base_o[BASE_ALIGN-1:0] == '0);

  a_r11_exit_locks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlocked_o && wr_i && port_sel_i && idx_q == 8'h02 && wdata_i[1]) |=> !unlocked_o);

  a_r12_idle_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> (rdata_o == 8'h00));
endmodule

bind sio_cfg_port sio_cfg_chk #(.BASE_ALIGN(BASE_ALIGN)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .alt_base_i   (alt_base_i),
  .port_sel_i   (port_sel_i),
  .wr_i         (wr_i),
  .rd_i         (rd_i),
  .wdata_i      (wdata_i),
  .rdata_o      (rdata_o),
  .unlocked_o   (unlocked_o),
  .flash_ctrl_o (flash_ctrl_o),
  .flash_base_o (flash_base_o),
  .idx_q        (idx_q)
);

// File: tb/sim_sio_cfg_port.sv
`timescale 1ns/1ps
module sim_sio_cfg_port;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        alt_base_i = 1'b0;
  logic        port_sel_i = 1'b0;
  logic        wr_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [7:0]  wdata_i = 8'h00;
  logic [7:0]  rdata_o;
  logic        unlocked_o;
  logic [7:0]  flash_ctrl_o;
  logic [15:0] flash_base_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  sio_cfg_port u0 (.*);

  always #5 clk_i = ~clk_i;

  // behavioural reference
  bit      m_unl;
  int      m_prog;
  int      m_idx, m_ldn, m_ctrl, m_bhi, m_blo;
  int      key[4];

  function automatic int m_reg(int i);
    if (i == 'h07) return m_ldn;
    if (i == 'h20) return 'h87;
    if (i == 'h21) return 'h16;
    if (i == 'h24) return m_ctrl;
    if (i == 'h64) return (m_ldn == 7) ? m_bhi : 0;
    if (i == 'h65) return (m_ldn == 7) ? m_blo : 0;
    return 0;
  endfunction

  function automatic int m_rdata();
    if (!rd_i) return 0;
    if (!m_unl) return 'hFF;
    return port_sel_i ? m_reg(m_idx) : m_idx;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_unl = 0; m_prog = 0; m_idx = 0; m_ldn = 0; m_ctrl = 0; m_bhi = 0; m_blo = 0;
    end else if (wr_i) begin
      key = '{'h87, 'h01, 'h55, alt_base_i ? 'hAA : 'h55};
      if (!port_sel_i) begin
        if (m_unl) m_idx = wdata_i;
        else if (int'(wdata_i) == key[m_prog]) begin
          if (m_prog == 3) begin m_unl = 1; m_prog = 0; end
          else m_prog++;
        end else m_prog = (wdata_i == 8'h87) ? 1 : 0;
      end else if (m_unl) begin
        case (m_idx)
          'h02: if (wdata_i[1]) m_unl = 0;
          'h07: m_ldn = wdata_i;
          'h24: m_ctrl = wdata_i;
          'h64: if (m_ldn == 7) m_bhi = wdata_i;
          'h65: if (m_ldn == 7) m_blo = wdata_i & 8'hF8;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle compare against the model
  always begin
    @(posedge clk_i);
    #1;
    if (rst_ni && !done) begin
      chk("R2 model unlocked_o", int'(unlocked_o), int'(m_unl));
      chk("R10 model flash_ctrl_o", int'(flash_ctrl_o), m_ctrl);
      chk("R9 model flash_base_o", int'(flash_base_o), (m_bhi << 8) | m_blo);
      chk("R6 model rdata_o", int'(rdata_o), m_rdata());
    end
  end

  task automatic wr(input bit p, input logic [7:0] d);
    port_sel_i = p; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(input bit p, input int exp, input string tag);
    port_sel_i = p; rd_i = 1'b1;
    #2;
    chk(tag, int'(rdata_o), exp);
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic key_seq(input logic [7:0] last);
    wr(0, 8'h87); wr(0, 8'h01); wr(0, 8'h55); wr(0, last);
  endtask

  task automatic reg_wr(input logic [7:0] i, input logic [7:0] d);
    wr(0, i); wr(1, d);
  endtask

  task automatic reg_rd(input logic [7:0] i, input int exp, input string tag);
    wr(0, i); rd(1, exp, tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 reset unlocked_o", int'(unlocked_o), 0);
    chk("R1 reset flash_ctrl_o", int'(flash_ctrl_o), 0);
    chk("R1 reset flash_base_o", int'(flash_base_o), 0);
    chk("R12 idle rdata_o", int'(rdata_o), 0);

    // locked behaviour
    rd(1, 'hFF, "R5 locked data read");
    rd(0, 'hFF, "R5 locked index read");
    wr(1, 8'h3C);
    chk("R5 locked data write", int'(flash_ctrl_o), 0);

    // primary key
    wr(0, 8'h87); wr(0, 8'h01); wr(0, 8'h55);
    chk("R2 three bytes stay locked", int'(unlocked_o), 0);
    wr(0, 8'h55);
    chk("R2 primary key unlocks", int'(unlocked_o), 1);

    wr(0, 8'h20);
    rd(0, 'h20, "R6 index readback");
    rd(1, 'h87, "R7 id high");
    reg_rd(8'h21, 'h16, "R7 id low");
    reg_wr(8'h21, 8'h00);
    reg_rd(8'h21, 'h16, "R7 id write ignored");

    reg_wr(8'h24, 8'h2E);
    reg_rd(8'h24, 'h2E, "R10 ctrl readback");
    chk("R10 ctrl port", int'(flash_ctrl_o), 'h2E);

    reg_wr(8'h64, 8'h12);
    reg_rd(8'h64, 'h00, "R8 base hidden in ldn 0");
    chk("R8 base write ignored in ldn 0", int'(flash_base_o), 0);
    reg_wr(8'h07, 8'h07);
    reg_rd(8'h07, 'h07, "R8 ldn readback");
    reg_wr(8'h64, 8'h0A);
    reg_wr(8'h65, 8'hFF);
    chk("R9 base aligned", int'(flash_base_o), 'h0AF8);
    reg_rd(8'h65, 'hF8, "R9 base low readback");
    reg_wr(8'h07, 8'h03);
    reg_wr(8'h65, 8'h40);
    reg_rd(8'h65, 'h00, "R8 other ldn reads zero");
    reg_wr(8'h07, 8'h07);
    reg_rd(8'h64, 'h0A, "R8 base kept high");
    reg_rd(8'h65, 'hF8, "R8 base kept low");

    reg_wr(8'h30, 8'h5A);
    reg_rd(8'h30, 'h00, "R12 unimplemented reg");
    reg_rd(8'h02, 'h00, "R12 exit reg reads zero");

    reg_wr(8'h02, 8'h01);
    chk("R11 exit without bit1", int'(unlocked_o), 1);
    reg_wr(8'h02, 8'h02);
    chk("R11 exit locks", int'(unlocked_o), 0);
    rd(0, 'hFF, "R5 locked after exit");
    wr(1, 8'h00);
    chk("R5 locked write keeps ctrl", int'(flash_ctrl_o), 'h2E);

    // restart on broken key
    wr(0, 8'h87); wr(0, 8'h01);
    key_seq(8'h55);
    chk("R4 restart on 0x87", int'(unlocked_o), 1);
    reg_wr(8'h02, 8'h02);
    wr(0, 8'h87); wr(0, 8'h42);
    wr(0, 8'h01); wr(0, 8'h55); wr(0, 8'h55);
    chk("R4 broken key stays locked", int'(unlocked_o), 0);

    key_seq(8'hAA);
    chk("R3 AA ignored at primary", int'(unlocked_o), 0);

    alt_base_i = 1'b1;
    key_seq(8'h55);
    chk("R3 55 ignored at alternate", int'(unlocked_o), 0);
    key_seq(8'hAA);
    chk("R3 alternate key unlocks", int'(unlocked_o), 1);
    reg_rd(8'h20, 'h87, "R7 id after alternate unlock");
    reg_wr(8'h02, 8'hFF);
    chk("R11 exit with all bits", int'(unlocked_o), 0);

    repeat (2) @(negedge clk_i);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule